// File: doc/BRIEF.md
# Electroluminescent Panel Scan Timing Generator

This block produces the raster waveform for a 640 by 400 monochrome electroluminescent panel that stores no image of its own and must be refreshed continuously, one bit per pixel. It walks a frame of line and column counters, fetches two-pixel words from an external synchronous memory read port with one cycle of latency, and drives a video clock enable, two pixel data lanes, an active-low horizontal sync and an active-high vertical sync. Every line ends with a short sync burst of blank clocks, the first line carries a brief vertical sync pulse that starts at its mid-point, and each frame closes with one all-blank line. That last line's sync makes the panel write out its final row.

A mode input picks one pixel per clock on lane 0, or two neighbouring pixels per clock on both lanes. The active part of each line then takes half as many clocks. Scanning starts when the start input is raised. Frames then follow back to back, and scanning stops only at a frame boundary once start is dropped. Line number and frame-start outputs let surrounding logic follow the raster.

Top module: `elp_scan_gen`

## Requirements
- R1: After reset, and whenever no scan is running, vclk_en_o is 0, hsync_n_o is 1, vsync_o is 0, vid0_o and vid1_o are 0, frame_start_o is 0 and line_o is 0.
- R2: Memory word bit 0 holds the even (left) pixel and bit 1 the odd pixel of the pair at address line*(H_PIX/2) + x/2. In dual mode, at active column c the lanes show vid0_o = bit 0 and vid1_o = bit 1 of word line*(H_PIX/2)+c. In single mode they show vid0_o = bit (c mod 2) of word line*(H_PIX/2)+c/2, with vid1_o = 0.
- R3: Each line has A active clocks (A = H_PIX/2 in dual mode, H_PIX in single mode). These are followed by exactly HS_CLKS clocks with hsync_n_o low and both lanes low. hsync_n_o is high in every other cycle.
- R4: line_o counts 0 to V_LINES-1 for the image lines, then V_LINES for one extra line whose lanes stay low while its sync burst is still sent.
- R5: vsync_o is high only in line 0, for exactly VS_CLKS clocks starting at column A/2.
- R6: When start_i is sampled high while idle, the first output cycle of the frame appears two clock edges later. frame_start_o is high for exactly that one cycle at line 0, column 0.
- R7: While start_i stays high, the next frame begins directly after the last clock of the blank line, with no idle cycle.
- R8: Dropping start_i mid-frame lets the current frame finish. The block then returns to the idle state of R1.
- R9: dual_mode_i is sampled only when a scan starts from idle. Changes while scanning do not affect the lanes or the line length.
- R10: vclk_en_o is high in every cycle of a running scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run request; a stop takes effect at frame end |
| dual_mode_i | input | 1 | 1 = two pixels per clock, 0 = one pixel per clock |
| mem_addr_o | output | ADDR_W | Read address of the pixel-pair word |
| mem_data_i | input | 2 | Word read one cycle after its address |
| vclk_en_o | output | 1 | Video clock enable |
| vid0_o | output | 1 | Pixel lane 0 |
| vid1_o | output | 1 | Pixel lane 1 |
| hsync_n_o | output | 1 | Line sync, active low |
| vsync_o | output | 1 | Frame sync, active high |
| line_o | output | LINE_W | Line number of the current output cycle |
| frame_start_o | output | 1 | One-cycle pulse at line 0, column 0 |

## Verification
On every cycle, the checker verifies the following: the length of each line sync burst and of the vertical sync pulse, the confinement of vertical sync to line 0, blank lanes during line sync, a quiet idle state, and line numbers that only step by one or wrap after the blank line. The bench compares each output cycle against an arithmetic model of the frame. Only this comparison can show several things: that the pixel mapping into the memory word is right in both modes, that the first frame starts with the correct latency, that frames follow each other without a gap, that a stop waits for the frame boundary, and that a mode change during a scan is ignored.

// File: rtl/elp_pkg.sv
package elp_pkg;
   typedef enum logic {
      MODE_SINGLE = 1'b0,
      MODE_DUAL   = 1'b1
   } lane_mode_e;

   typedef struct packed {
      logic run;
      logic pix;
      logic sel;
      logic dual;
      logic hs;
      logic vs;
      logic fs;
   } out_stage_t;
endpackage

// File: rtl/elp_hcount.sv
module elp_hcount #(
   parameter int H_PIX   = 640,
   parameter int HS_CLKS = 4,
   parameter int VS_CLKS = 8,
   parameter int COL_W   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             dual,
   output logic [COL_W-1:0] col,
   output logic             line_end,
   output logic             act,
   output logic             hs_win,
   output logic             vs_win
);
   localparam int ACT_DUAL   = H_PIX / 2;
   localparam int ACT_SINGLE = H_PIX;

   logic [COL_W-1:0] act_len;
   logic [COL_W-1:0] half;

   assign act_len  = dual ? COL_W'(ACT_DUAL) : COL_W'(ACT_SINGLE);
   assign half     = dual ? COL_W'(ACT_DUAL / 2) : COL_W'(ACT_SINGLE / 2);
   assign line_end = (col == act_len + COL_W'(HS_CLKS - 1));
   assign act      = (col < act_len);
   assign hs_win   = !act;
   assign vs_win   = (col >= half) && (col < half + COL_W'(VS_CLKS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            col <= '0;
      else if (!run)         col <= '0;
      else if (line_end)     col <= '0;
      else                   col <= col + COL_W'(1);
   end
endmodule

// File: rtl/elp_vcount.sv
module elp_vcount
   import elp_pkg::*;
#(
   parameter int V_LINES = 400,
   parameter int LINE_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode_in,
   input  logic              line_end,
   output logic              run,
   output logic              dual,
   output logic [LINE_W-1:0] line
);
   logic frame_last;
   assign frame_last = line_end && (line == LINE_W'(V_LINES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         dual <= MODE_SINGLE;
         line <= '0;
      end else if (!run) begin
         line <= '0;
         if (start) begin
            run  <= 1'b1;
            dual <= mode_in;
         end
      end else if (frame_last) begin
         line <= '0;
         if (!start) run <= 1'b0;
      end else if (line_end) begin
         line <= line + LINE_W'(1);
      end
   end
endmodule

// File: rtl/elp_pixstage.sv
module elp_pixstage
   import elp_pkg::*;
#(
   parameter int H_PIX   = 640,
   parameter int V_LINES = 400,
   parameter int COL_W   = 10,
   parameter int LINE_W  = 9,
   parameter int ADDR_W  = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              dual,
   input  logic [LINE_W-1:0] line,
   input  logic [COL_W-1:0]  col,
   input  logic              act,
   input  logic              hs_win,
   input  logic              vs_win,
   input  logic [1:0]        mem_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              vclk_en,
   output logic              vid0,
   output logic              vid1,
   output logic              hsync_n,
   output logic              vsync,
   output logic [LINE_W-1:0] line_q,
   output logic              frame_start
);
   logic              row_act;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] offs;
   out_stage_t        nxt, q;
   logic [1:0]        lane;

   assign row_act  = (line < LINE_W'(V_LINES)) && act;
   assign base     = ADDR_W'(line) * ADDR_W'(H_PIX / 2);
   assign offs     = dual ? ADDR_W'(col) : ADDR_W'(col >> 1);
   assign mem_addr = row_act ? base + offs : '0;

   always_comb begin
      nxt.run  = run;
      nxt.pix  = run && row_act;
      nxt.sel  = col[0];
      nxt.dual = dual;
      nxt.hs   = run && hs_win;
      nxt.vs   = run && vs_win && (line == '0);
      nxt.fs   = run && (col == '0) && (line == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= '0;
         line_q <= '0;
      end else begin
         q      <= nxt;
         line_q <= line;
      end
   end

   for (genvar k = 0; k < 2; k++) begin : g_lane
      if (k == 0) begin : g_lead
         assign lane[k] = q.pix && (q.dual ? mem_data[0] : mem_data[q.sel]);
      end else begin : g_trail
         assign lane[k] = q.pix && q.dual && mem_data[1];
      end
   end

   assign vid0        = lane[0];
   assign vid1        = lane[1];
   assign vclk_en     = q.run;
   assign hsync_n     = !q.hs;
   assign vsync       = q.vs;
   assign frame_start = q.fs;
endmodule

// File: rtl/elp_scan_gen.sv
module elp_scan_gen #(
   parameter int H_PIX   = 640,
   parameter int V_LINES = 400,
   parameter int HS_CLKS = 4,
   parameter int VS_CLKS = 8,
   parameter int COL_W   = $clog2(H_PIX + HS_CLKS),
   parameter int LINE_W  = $clog2(V_LINES + 1),
   parameter int ADDR_W  = $clog2((H_PIX / 2) * V_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              dual_mode_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [1:0]        mem_data_i,
   output logic              vclk_en_o,
   output logic              vid0_o,
   output logic              vid1_o,
   output logic              hsync_n_o,
   output logic              vsync_o,
   output logic [LINE_W-1:0] line_o,
   output logic              frame_start_o
);
   if (H_PIX % 2 != 0 || H_PIX < 4) begin : g_bad_width
      $error("H_PIX must be even and at least 4");
   end
   if (VS_CLKS < 1 || VS_CLKS > H_PIX / 4) begin : g_bad_vs
      $error("VS_CLKS must fit in the second half of a dual-mode line");
   end
   if (HS_CLKS < 1 || V_LINES < 1) begin : g_bad_counts
      $error("HS_CLKS and V_LINES must be positive");
   end

   logic              run, dual, line_end, act, hs_win, vs_win;
   logic [COL_W-1:0]  col;
   logic [LINE_W-1:0] line;

   elp_vcount #(.V_LINES(V_LINES), .LINE_W(LINE_W)) i_vcount (
      .clk(clk), .rst_n(rst_n), .start(start_i), .mode_in(dual_mode_i),
      .line_end(line_end), .run(run), .dual(dual), .line(line)
   );

   elp_hcount #(.H_PIX(H_PIX), .HS_CLKS(HS_CLKS), .VS_CLKS(VS_CLKS),
                .COL_W(COL_W)) i_hcount (
      .clk(clk), .rst_n(rst_n), .run(run), .dual(dual), .col(col),
      .line_end(line_end), .act(act), .hs_win(hs_win), .vs_win(vs_win)
   );

   elp_pixstage #(.H_PIX(H_PIX), .V_LINES(V_LINES), .COL_W(COL_W),
                  .LINE_W(LINE_W), .ADDR_W(ADDR_W)) i_pixstage (
      .clk(clk), .rst_n(rst_n), .run(run), .dual(dual), .line(line),
      .col(col), .act(act), .hs_win(hs_win), .vs_win(vs_win),
      .mem_data(mem_data_i), .mem_addr(mem_addr_o), .vclk_en(vclk_en_o),
      .vid0(vid0_o), .vid1(vid1_o), .hsync_n(hsync_n_o), .vsync(vsync_o),
      .line_q(line_o), .frame_start(frame_start_o)
   );
endmodule

// File: rtl/elp_scan_chk.sv
module elp_scan_chk #(
   parameter int V_LINES = 400,
   parameter int HS_CLKS = 4,
   parameter int VS_CLKS = 8,
   parameter int LINE_W  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vclk_en_o,
   input logic              vid0_o,
   input logic              vid1_o,
   input logic              hsync_n_o,
   input logic              vsync_o,
   input logic [LINE_W-1:0] line_o,
   input logic              frame_start_o
);
   logic [15:0] hs_run, vs_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_run <= '0;
         vs_run <= '0;
      end else begin
         hs_run <= hsync_n_o ? 16'd0 : hs_run + 16'd1;
         vs_run <= vsync_o ? vs_run + 16'd1 : 16'd0;
      end
   end

   p_hs_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hsync_n_o) |-> hs_run == 16'(HS_CLKS));
   p_hs_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !hsync_n_o |-> !vid0_o && !vid1_o);
   p_vs_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vsync_o) |-> vs_run == 16'(VS_CLKS));
   p_vs_line0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vsync_o |-> line_o == '0 && hsync_n_o);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !vclk_en_o |-> hsync_n_o && !vsync_o && !vid0_o && !vid1_o && !frame_start_o);
   p_fs_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |-> vclk_en_o && line_o == '0);
   p_line_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vclk_en_o && $past(vclk_en_o) && line_o != $past(line_o)) |->
      (line_o == $past(line_o) + LINE_W'(1)) ||
      (line_o == '0 && $past(line_o) == LINE_W'(V_LINES)));
endmodule

bind elp_scan_gen elp_scan_chk #(
   .V_LINES(V_LINES), .HS_CLKS(HS_CLKS), .VS_CLKS(VS_CLKS), .LINE_W(LINE_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .vclk_en_o(vclk_en_o), .vid0_o(vid0_o),
   .vid1_o(vid1_o), .hsync_n_o(hsync_n_o), .vsync_o(vsync_o),
   .line_o(line_o), .frame_start_o(frame_start_o)
);

// File: tb/test_elp_scan_gen.sv
module test_elp_scan_gen;
   localparam int H  = 8;
   localparam int V  = 3;
   localparam int HS = 4;
   localparam int VS = 2;
   localparam int LW = $clog2(V + 1);
   localparam int AW = $clog2((H / 2) * V);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          dual_mode = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [1:0]    mem_q = 2'b00;
   logic          vclk_en, vid0, vid1, hsync_n, vsync, frame_start;
   logic [LW-1:0] line_no;
   int            n_checks = 0;
   int            n_fail = 0;
   bit            done = 1'b0;

   always #5 clk = ~clk;

   elp_scan_gen #(.H_PIX(H), .V_LINES(V), .HS_CLKS(HS), .VS_CLKS(VS)) i_elp_scan_gen (
      .clk(clk), .rst_n(rst_n), .start_i(start), .dual_mode_i(dual_mode),
      .mem_addr_o(mem_addr), .mem_data_i(mem_q), .vclk_en_o(vclk_en),
      .vid0_o(vid0), .vid1_o(vid1), .hsync_n_o(hsync_n), .vsync_o(vsync),
      .line_o(line_no), .frame_start_o(frame_start)
   );

   function automatic logic [1:0] memf(int a);
      return 2'((a * 7 + (a >> 1)) ^ (a >> 3));
   endfunction

   always_ff @(posedge clk) mem_q <= memf(int'(mem_addr));

   task automatic chk(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_idle(string req);
      chk(req, int'(vclk_en), 0);
      chk(req, int'(hsync_n), 1);
      chk(req, int'(vsync), 0);
      chk(req, int'({vid1, vid0}), 0);
      chk(req, int'(frame_start), 0);
      chk(req, int'(line_no), 0);
   endtask

   task automatic run_scan(bit d, int frames, bit toggle);
      int a_len = d ? H / 2 : H;
      int l_len = a_len + HS;
      int f_len = l_len * (V + 1);
      @(negedge clk);
      start = 1'b1;
      dual_mode = d;
      @(negedge clk);
      chk("R6 latency", int'(vclk_en), 0);
      for (int i = 0; i < frames * f_len; i++) begin
         int p, ln, col, a, e0, e1, evs;
         logic [1:0] w;
         @(negedge clk);
         p   = i % f_len;
         ln  = p / l_len;
         col = p % l_len;
         e0 = 0; e1 = 0;
         if (ln < V && col < a_len) begin
            a = ln * (H / 2) + (d ? col : col / 2);
            w = memf(a);
            e0 = d ? int'(w[0]) : int'(w[col % 2]);
            e1 = d ? int'(w[1]) : 0;
         end
         evs = (ln == 0 && col >= a_len / 2 && col < a_len / 2 + VS) ? 1 : 0;
         chk(toggle ? "R9 lanes" : "R2 lanes", int'({vid1, vid0}), e1 * 2 + e0);
         chk("R3 hsync", int'(hsync_n), (col >= a_len) ? 0 : 1);
         chk("R4 line", int'(line_no), ln);
         chk("R5 vsync", int'(vsync), evs);
         chk((i == f_len) ? "R7 restart" : "R6 frame_start", int'(frame_start), (p == 0) ? 1 : 0);
         chk("R10 vclk_en", int'(vclk_en), 1);
         if (toggle && i == 5) dual_mode = ~d;
         if (i == (frames - 1) * f_len + 3) start = 1'b0;
      end
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk_idle("R8 stop");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_idle("R1 reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk_idle("R1 idle");
      dual_mode = 1'b1;
      repeat (3) @(negedge clk);
      chk_idle("R1 idle mode change");
      run_scan(1'b1, 2, 1'b0);
      run_scan(1'b0, 2, 1'b1);
      run_scan(1'b1, 1, 1'b0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule